// File: doc/BRIEF.md
# SMI Status Aggregation and Wake Router

This block holds the 16-bit global status word for system-management interrupt sources. Hardware events latch into sticky bits, and software clears each bit by writing a 1 to its position. A few bit positions are not stored. They show the live OR of status words kept elsewhere. The block also drives a level SMI request from the enabled sticky bits. An external GPIO event is steered to SMI, to wake, or to both, depending on the current sleep state.

An ECC interrupt line is qualified by its pulse width. When the SERR enable is set, the line must be high on consecutive clocks before it is accepted. When that enable is clear, one clock is enough. The timers, the bus decode and the neighbouring status words stay outside the block and reach it as plain inputs.

Top module: `smi_status_hub`

## Requirements
- R1: After reset, `rd_data_o` reads 0000h and `smi_o` and `wake_o` are low. Bits 15:11 and bit 2 always read 0, even when every source is active.
- R2: With `ecc_serr_en_i` high, bit 10 sets only after `ecc_int_i` has been high on two consecutive clock edges. A single-cycle pulse leaves bit 10 clear.
- R3: With `ecc_serr_en_i` low, a single clock of `ecc_int_i` sets bit 10.
- R4: A register write (`wr_en_i` high) clears exactly those sticky bits whose `wr_data_i` bit is 1. Bits written with 0 keep their value.
- R5: If a hardware set and a write-one-to-clear hit the same bit in the same cycle, the bit stays set.
- R6: Bit 5 reads the OR of `gp_sts_i`. Bit 4 reads the OR of `pm1_sts_i`. Bit 1 reads the OR of `usb_sts_i & usb_en_i`. None of these three bits is stored.
- R7: `smi_o` is a level that stays high while any of the following holds: bit 10 is set with `ecc_smi_en_i` high, bit 3 is set with `apm_en_i` high, or any of bits 9, 7, 6 or 0 is set.
- R8: While bit 8 is set and `ext_en_i` is high, the routing follows `pwr_state_i` (encoding S0=0, S1=1, S3=3, S4=4, S5=5):
  - S0 with `cstate_i` of 0, 1 or 2 gives SMI only.
  - S0 with `cstate_i` of 3 gives nothing.
  - S1 gives both SMI and wake.
  - S3, S4 and S5 give wake only.
  - With `ext_en_i` low, bit 8 gives neither SMI nor wake.
- R9: Bit 0 sets when `rls_wr_i` is high while `bios_en_i` is high. `rls_wr_i` alone or `bios_en_i` alone does nothing. Bit 3 sets on `apm_wr_i` whether or not `apm_en_i` is set.
- R10: Bit 9 sets while `bios_wen_i` is high. Bit 8 sets on `ext_req_i`. Bit 7 sets on `swtmr_exp_i`. Bit 6 sets on `min_exp_i`. Each of these is visible in the cycle after the triggering edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_int_i | input | 1 | ECC interrupt line, active high |
| ecc_serr_en_i | input | 1 | Selects the two-cycle ECC qualification |
| ecc_smi_en_i | input | 1 | Lets bit 10 drive SMI |
| bios_wen_i | input | 1 | BIOS write-enable flag |
| ext_req_i | input | 1 | GPIO input routed to SMI is active |
| ext_en_i | input | 1 | Enables routing of bit 8 |
| pwr_state_i | input | 3 | Sleep state code |
| cstate_i | input | CST_W | Processor C-state, used in S0 only |
| swtmr_exp_i | input | 1 | Software SMI timer expiry strobe |
| min_exp_i | input | 1 | One-minute timer expiry strobe |
| apm_wr_i | input | 1 | Write strobe to the APM control port |
| apm_en_i | input | 1 | Lets bit 3 drive SMI |
| rls_wr_i | input | 1 | Software wrote 1 to the global release bit |
| bios_en_i | input | 1 | Qualifies the release write |
| gp_sts_i | input | GP_W | General-purpose status word |
| pm1_sts_i | input | PM1_W | Power-management status word |
| usb_sts_i | input | USB_W | Legacy USB SMI status bits |
| usb_en_i | input | USB_W | Legacy USB SMI enable bits |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data; 1 clears a sticky bit |
| rd_data_o | output | 16 | Register read value |
| smi_o | output | 1 | SMI request level |
| wake_o | output | 1 | Wake request level |

## Verification
The collision that matters is a hardware set and a software clear landing on the same status bit in the same clock. The bench provokes it by pulsing the software timer expiry in the cycle that writes 1 to bit 7. It judges the result by requiring that bit 7 reads back set, with `smi_o` still high. A second overlap arises when an ECC pulse is one clock too short in SERR mode while writes are idle. The bench checks that bit 10 stays clear after the short pulse and sets only on the second consecutive high edge.

// File: rtl/smi_pkg.sv
package smi_pkg;
   localparam int REG_W = 16;

   // status bit positions; software decodes these
   localparam int B_ECC   = 10;
   localparam int B_BWEN  = 9;
   localparam int B_EXT   = 8;
   localparam int B_SWTMR = 7;
   localparam int B_MIN   = 6;
   localparam int B_GP    = 5;
   localparam int B_PM1   = 4;
   localparam int B_APM   = 3;
   localparam int B_USB   = 1;
   localparam int B_BIOS  = 0;

   localparam logic [REG_W-1:0] STICKY_MASK = 16'h07C9;

   // sleep state codes
   localparam logic [2:0] PS_S0 = 3'd0;
   localparam logic [2:0] PS_S1 = 3'd1;
   localparam logic [2:0] PS_S3 = 3'd3;
   localparam logic [2:0] PS_S4 = 3'd4;
   localparam logic [2:0] PS_S5 = 3'd5;
endpackage

// File: rtl/smi_ecc_qual.sv
module smi_ecc_qual #(
   parameter int MIN_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic serr_en_i,
   output logic evt_o
);
   localparam int CW = $clog2(MIN_CYC + 1);

   generate
      if (MIN_CYC < 2) begin : g_bad_min
         $error("smi_ecc_qual: MIN_CYC must be at least 2");
      end
   endgenerate

   logic [CW-1:0] run_q;
   logic          long_ok;

   always_ff @(posedge clk) begin
      if (!rst_n)                    run_q <= '0;
      else if (!line_i)              run_q <= '0;
      else if (run_q != CW'(MIN_CYC)) run_q <= run_q + 1'b1;
   end

   assign long_ok = (run_q >= CW'(MIN_CYC - 1));
   assign evt_o   = line_i & (serr_en_i ? long_ok : 1'b1);

   generate
      if (MIN_CYC == 2) begin : g_chk2
         p_ecc_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (serr_en_i && evt_o) |-> $past(line_i))
            else $error("R2: ECC accepted without prior high cycle");
      end
   endgenerate
endmodule

// File: rtl/smi_sticky_bit.sv
module smi_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= set_i | (q_o & ~clr_i);
   end

   p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o) else $error("R5: set lost");
   p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o) else $error("R4: clear ignored");
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o && !clr_i) |=> q_o) else $error("R4: bit dropped");
endmodule

// File: rtl/smi_wake_route.sv
module smi_wake_route
   import smi_pkg::*;
#(
   parameter int CST_W   = 2,
   parameter int MAX_CST = 2
) (
   input  logic             sts_i,
   input  logic             en_i,
   input  logic [2:0]       pwr_i,
   input  logic [CST_W-1:0] cst_i,
   output logic             smi_o,
   output logic             wake_o
);
   generate
      if (MAX_CST >= (1 << CST_W)) begin : g_bad_cst
         $error("smi_wake_route: MAX_CST exceeds C-state width");
      end
   endgenerate

   always_comb begin
      smi_o  = 1'b0;
      wake_o = 1'b0;
      if (sts_i && en_i) begin
         case (pwr_i)
            PS_S0: smi_o = (cst_i <= CST_W'(MAX_CST));
            PS_S1: begin
               smi_o  = 1'b1;
               wake_o = 1'b1;
            end
            PS_S3, PS_S4, PS_S5: wake_o = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/smi_status_hub.sv
module smi_status_hub
   import smi_pkg::*;
#(
   parameter int GP_W        = 8,
   parameter int PM1_W       = 16,
   parameter int USB_W       = 4,
   parameter int ECC_MIN_CYC = 2,
   parameter int CST_W       = 2,
   parameter int SMI_MAX_CST = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ecc_int_i,
   input  logic             ecc_serr_en_i,
   input  logic             ecc_smi_en_i,
   input  logic             bios_wen_i,
   input  logic             ext_req_i,
   input  logic             ext_en_i,
   input  logic [2:0]       pwr_state_i,
   input  logic [CST_W-1:0] cstate_i,
   input  logic             swtmr_exp_i,
   input  logic             min_exp_i,
   input  logic             apm_wr_i,
   input  logic             apm_en_i,
   input  logic             rls_wr_i,
   input  logic             bios_en_i,
   input  logic [GP_W-1:0]  gp_sts_i,
   input  logic [PM1_W-1:0] pm1_sts_i,
   input  logic [USB_W-1:0] usb_sts_i,
   input  logic [USB_W-1:0] usb_en_i,
   input  logic             wr_en_i,
   input  logic [15:0]      wr_data_i,
   output logic [15:0]      rd_data_o,
   output logic             smi_o,
   output logic             wake_o
);
   generate
      if (GP_W < 1 || PM1_W < 1 || USB_W < 1) begin : g_bad_w
         $error("smi_status_hub: summary widths must be positive");
      end
   endgenerate

   logic             ecc_evt;
   logic [REG_W-1:0] set_vec, clr_vec, sts_q, smi_en_vec, live_vec;
   logic             ext_smi, ext_wake;
   logic             unused_bits;

   smi_ecc_qual #(.MIN_CYC(ECC_MIN_CYC)) u_ecc (
      .clk(clk), .rst_n(rst_n), .line_i(ecc_int_i),
      .serr_en_i(ecc_serr_en_i), .evt_o(ecc_evt));

   always_comb begin
      set_vec          = '0;
      set_vec[B_ECC]   = ecc_evt;
      set_vec[B_BWEN]  = bios_wen_i;
      set_vec[B_EXT]   = ext_req_i;
      set_vec[B_SWTMR] = swtmr_exp_i;
      set_vec[B_MIN]   = min_exp_i;
      set_vec[B_APM]   = apm_wr_i;
      set_vec[B_BIOS]  = rls_wr_i & bios_en_i;
   end

   assign clr_vec = wr_en_i ? wr_data_i : '0;

   genvar gi;
   generate
      for (gi = 0; gi < REG_W; gi++) begin : g_bit
         if (STICKY_MASK[gi]) begin : g_st
            smi_sticky_bit u_bit (
               .clk(clk), .rst_n(rst_n), .set_i(set_vec[gi]),
               .clr_i(clr_vec[gi]), .q_o(sts_q[gi]));
         end else begin : g_none
            assign sts_q[gi] = 1'b0;
         end
      end
   endgenerate

   assign unused_bits = ^(clr_vec & ~STICKY_MASK) ^ ^(set_vec & ~STICKY_MASK);

   always_comb begin
      live_vec        = '0;
      live_vec[B_GP]  = |gp_sts_i;
      live_vec[B_PM1] = |pm1_sts_i;
      live_vec[B_USB] = |(usb_sts_i & usb_en_i);
   end

   assign rd_data_o = sts_q | live_vec;

   always_comb begin
      smi_en_vec          = '0;
      smi_en_vec[B_ECC]   = ecc_smi_en_i;
      smi_en_vec[B_BWEN]  = 1'b1;
      smi_en_vec[B_SWTMR] = 1'b1;
      smi_en_vec[B_MIN]   = 1'b1;
      smi_en_vec[B_APM]   = apm_en_i;
      smi_en_vec[B_BIOS]  = 1'b1;
   end

   smi_wake_route #(.CST_W(CST_W), .MAX_CST(SMI_MAX_CST)) u_route (
      .sts_i(sts_q[B_EXT]), .en_i(ext_en_i), .pwr_i(pwr_state_i),
      .cst_i(cstate_i), .smi_o(ext_smi), .wake_o(ext_wake));

   assign smi_o  = (|(sts_q & smi_en_vec)) | ext_smi;
   assign wake_o = ext_wake;

   p_smi_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      smi_o |-> (|sts_q)) else $error("R7: SMI without status");
   p_wake_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> (rd_data_o[B_EXT] && ext_en_i)) else $error("R8: stray wake");
   p_both_s1_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_wake && ext_smi) |-> (pwr_state_i == PS_S1))
      else $error("R8: SMI with wake outside S1");
   p_rst_clean_r1: assert property (@(posedge clk)
      !rst_n |=> (sts_q == '0)) else $error("R1: reset state");
endmodule

// File: tb/sim_smi_status_hub.sv
`timescale 1ns/1ps
module sim_smi_status_hub;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ecc_int_i = 0, ecc_serr_en_i = 0, ecc_smi_en_i = 0;
   logic        bios_wen_i = 0, ext_req_i = 0, ext_en_i = 0;
   logic [2:0]  pwr_state_i = 3'd0;
   logic [1:0]  cstate_i = 2'd0;
   logic        swtmr_exp_i = 0, min_exp_i = 0, apm_wr_i = 0, apm_en_i = 0;
   logic        rls_wr_i = 0, bios_en_i = 0;
   logic [7:0]  gp_sts_i = '0;
   logic [15:0] pm1_sts_i = '0;
   logic [3:0]  usb_sts_i = '0, usb_en_i = '0;
   logic        wr_en_i = 0;
   logic [15:0] wr_data_i = '0;
   logic [15:0] rd_data_o;
   logic        smi_o, wake_o;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   smi_status_hub u0 (.*);

   // {events(swtmr,min,apm,rls,bios_en,bioswen,ecc), apm_en, ecc_en, rd, smi}
   localparam int NV = 10;
   localparam logic [25:0] VEC [NV] = '{
      {7'b0000001, 1'b0, 1'b1, 16'h0400, 1'b1},
      {7'b0000001, 1'b0, 1'b0, 16'h0400, 1'b0},
      {7'b0000010, 1'b0, 1'b0, 16'h0200, 1'b1},
      {7'b1000000, 1'b0, 1'b0, 16'h0080, 1'b1},
      {7'b0100000, 1'b0, 1'b0, 16'h0040, 1'b1},
      {7'b0010000, 1'b1, 1'b0, 16'h0008, 1'b1},
      {7'b0010000, 1'b0, 1'b0, 16'h0008, 1'b0},
      {7'b0001100, 1'b0, 1'b0, 16'h0001, 1'b1},
      {7'b0001000, 1'b0, 1'b0, 16'h0000, 1'b0},
      {7'b0000100, 1'b0, 1'b0, 16'h0000, 1'b0}
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [15:0] e_rd,
                      input logic e_smi, input logic e_wake);
      n_chk++;
      if (rd_data_o !== e_rd || smi_o !== e_smi || wake_o !== e_wake) begin
         n_fail++;
         $display("FAIL %s: rd=%h smi=%b wake=%b expected rd=%h smi=%b wake=%b",
                  req, rd_data_o, smi_o, wake_o, e_rd, e_smi, e_wake);
      end
   endtask

   task automatic clear_all();
      wr_en_i = 1; wr_data_i = 16'hFFFF;
      tick();
      wr_en_i = 0; wr_data_i = '0;
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset", 16'h0000, 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         {swtmr_exp_i, min_exp_i, apm_wr_i, rls_wr_i, bios_en_i, bios_wen_i,
          ecc_int_i} = VEC[i][25:19];
         apm_en_i = VEC[i][18];
         ecc_smi_en_i = VEC[i][17];
         tick();
         {swtmr_exp_i, min_exp_i, apm_wr_i, rls_wr_i, bios_en_i, bios_wen_i,
          ecc_int_i} = '0;
         chk($sformatf("R10/R9/R7/R3 vector %0d", i), VEC[i][16:1], VEC[i][0], 1'b0);
         clear_all();
         apm_en_i = 0; ecc_smi_en_i = 0;
         chk($sformatf("R4 clear after vector %0d", i), 16'h0000, 1'b0, 1'b0);
      end

      // R2: qualified ECC
      ecc_serr_en_i = 1; ecc_smi_en_i = 1;
      ecc_int_i = 1; tick(); ecc_int_i = 0; tick();
      chk("R2 short pulse ignored", 16'h0000, 1'b0, 1'b0);
      ecc_int_i = 1; tick();
      chk("R2 first edge", 16'h0000, 1'b0, 1'b0);
      tick(); ecc_int_i = 0;
      chk("R2 second edge", 16'h0400, 1'b1, 1'b0);
      clear_all(); ecc_serr_en_i = 0; ecc_smi_en_i = 0;
      // R3: single cycle without SERR
      ecc_int_i = 1; tick(); ecc_int_i = 0;
      chk("R3 single cycle", 16'h0400, 1'b0, 1'b0);
      clear_all();

      // R4: write 0 keeps, write 1 clears only its bit
      min_exp_i = 1; swtmr_exp_i = 1; tick(); min_exp_i = 0; swtmr_exp_i = 0;
      wr_en_i = 1; wr_data_i = 16'h0000; tick(); wr_en_i = 0;
      chk("R4 write zero", 16'h00C0, 1'b1, 1'b0);
      wr_en_i = 1; wr_data_i = 16'h0040; tick(); wr_en_i = 0; wr_data_i = '0;
      chk("R4 selective clear", 16'h0080, 1'b1, 1'b0);

      // R5: set and clear in the same cycle
      swtmr_exp_i = 1; wr_en_i = 1; wr_data_i = 16'h0080; tick();
      swtmr_exp_i = 0; wr_en_i = 0; wr_data_i = '0;
      chk("R5 set beats clear", 16'h0080, 1'b1, 1'b0);
      wr_en_i = 1; wr_data_i = 16'h0080; tick(); wr_en_i = 0; wr_data_i = '0;
      chk("R5 later clear", 16'h0000, 1'b0, 1'b0);

      // R6: live summary bits
      gp_sts_i = 8'h10; #1;
      chk("R6 gp", 16'h0020, 1'b0, 1'b0);
      pm1_sts_i = 16'h8000; usb_sts_i = 4'b0101; usb_en_i = 4'b1010; #1;
      chk("R6 pm1, usb masked", 16'h0030, 1'b0, 1'b0);
      usb_en_i = 4'b0100; #1;
      chk("R6 usb", 16'h0032, 1'b0, 1'b0);
      gp_sts_i = '0; pm1_sts_i = '0; usb_sts_i = '0; usb_en_i = '0; #1;
      chk("R6 live drop", 16'h0000, 1'b0, 1'b0);

      // R8: external routing
      ext_en_i = 1; pwr_state_i = 3'd0; cstate_i = 2'd0;
      ext_req_i = 1; tick(); ext_req_i = 0;
      chk("R8 S0 C0", 16'h0100, 1'b1, 1'b0);
      cstate_i = 2'd2; #1; chk("R8 S0 C2", 16'h0100, 1'b1, 1'b0);
      cstate_i = 2'd3; #1; chk("R8 S0 C3", 16'h0100, 1'b0, 1'b0);
      pwr_state_i = 3'd1; #1; chk("R8 S1", 16'h0100, 1'b1, 1'b1);
      pwr_state_i = 3'd3; #1; chk("R8 S3", 16'h0100, 1'b0, 1'b1);
      pwr_state_i = 3'd4; #1; chk("R8 S4", 16'h0100, 1'b0, 1'b1);
      pwr_state_i = 3'd5; #1; chk("R8 S5", 16'h0100, 1'b0, 1'b1);
      pwr_state_i = 3'd1; ext_en_i = 0; #1;
      chk("R8 disabled", 16'h0100, 1'b0, 1'b0);
      clear_all(); pwr_state_i = 3'd0; cstate_i = 2'd0;

      // R1: reserved bits with every source active
      {swtmr_exp_i, min_exp_i, apm_wr_i, rls_wr_i, bios_en_i, bios_wen_i,
       ecc_int_i, ext_req_i} = '1;
      gp_sts_i = 8'h01; pm1_sts_i = 16'h0001; usb_sts_i = 4'h1; usb_en_i = 4'h1;
      tick();
      {swtmr_exp_i, min_exp_i, apm_wr_i, rls_wr_i, bios_en_i, bios_wen_i,
       ecc_int_i, ext_req_i} = '0;
      chk("R1 reserved zero", 16'h07FB, 1'b1, 1'b0);
      gp_sts_i = '0; pm1_sts_i = '0; usb_sts_i = '0; usb_en_i = '0;
      clear_all();
      chk("R1 all clear", 16'h0000, 1'b0, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule